// File: doc/BRIEF.md
# Immediate Operand Generator

This combinational block builds the 64-bit immediate operand for the second execution input. It takes a 32-bit instruction word and a 4-bit operand-select code. From one of several constant fields in the instruction it returns the operand value, a flag saying the operand is an immediate, and a flag for select codes that have no meaning. The instruction fields use big-endian bit numbering: field bit k is instruction bit 0 at the most significant end. So big-endian bit k is `insn[31-k]`.

A decode stage places this block after the stage that picks the operand format. The select code tells it which constant shape to build. Codes that choose a register, a special register or no operand at all leave the immediate path idle, and the output stays at zero.

Top module: `imm_operand_gen`

## Requirements
- R1: Select code 3 (unsigned half) gives big-endian bits 16..31 (`insn[15:0]`), zero-extended to 64 bits.
- R2: Select code 4 (signed half) gives big-endian bits 16..31, sign-extended to 64 bits from field bit 15 (`insn[15]`).
- R3: Select code 5 (unsigned high half) gives the bits 16..31 field shifted left by 16, zero-extended to 64 bits.
- R4: Select code 6 (signed high half) gives the bits 16..31 field shifted left by 16 as a 32-bit value, then sign-extended from bit 31 to 64 bits.
- R5: Select code 7 (long jump offset) gives big-endian bits 6..29 (`insn[25:2]`) shifted left by 2, zero-extended.
- R6: Select codes 8 (branch offset) and 9 (load/store displacement) give big-endian bits 16..29 (`insn[15:2]`) shifted left by 2, zero-extended.
- R7: Select code 10 gives a value with all 64 bits set.
- R8: Select code 11 (64-bit shift amount) gives a 6-bit value, zero-extended. Its bits 4..0 are big-endian bits 16..20 (`insn[15:11]`) and its bit 5 is big-endian bit 30 (`insn[1]`).
- R9: Select code 12 (32-bit shift amount) gives big-endian bits 16..20, zero-extended.
- R10: `imm_valid` is 1 for select codes 3 to 12. It is 0 for code 0 (no operand), code 1 (register) and code 2 (special register).
- R11: Whenever `imm_valid` is 0, `imm_value` is zero.
- R12: Select codes 13, 14 and 15 give `imm_valid` = 0 and `bad_sel` = 1. Every other code gives `bad_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word; big-endian bit k is insn[31-k] |
| opnd_sel | input | 4 | Operand-select code |
| imm_value | output | 64 | Immediate operand |
| imm_valid | output | 1 | Operand is an immediate constant |
| bad_sel | output | 1 | Select code is undefined |

## Verification
The embedded assertions re-check the output shape for every input change. They check that the value is zero when the valid flag is low and that the valid and bad-select flags never both rise. They also check the sign fill of the two signed modes, the two clear low bits of the word-aligned offsets, the zero upper part of the unsigned and shift-amount modes, and the all-ones pattern. Only the bench's scenarios can show that the right instruction bits land in the right output bits. That covers the split high bit of the 6-bit shift amount and the exact field boundaries. The bench compares against independently written field extractors over random words and chosen sign-boundary words.

// File: rtl/imm_gen_pkg.sv
package imm_gen_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPND_W = 64;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned JMP_W  = 24;
  localparam int unsigned OFS_W  = 14;
  localparam int unsigned SH_W   = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE    = 4'd0,
    SEL_GPR     = 4'd1,
    SEL_SPREG   = 4'd2,
    SEL_U16     = 4'd3,
    SEL_S16     = 4'd4,
    SEL_U16_HI  = 4'd5,
    SEL_S16_HI  = 4'd6,
    SEL_JUMP    = 4'd7,
    SEL_BRANCH  = 4'd8,
    SEL_DISP    = 4'd9,
    SEL_ONES    = 4'd10,
    SEL_SHAMT6  = 4'd11,
    SEL_SHAMT5  = 4'd12
  } imm_sel_e;

  typedef struct packed {
    logic [HALF_W-1:0] half;
    logic [JMP_W-1:0]  jump;
    logic [OFS_W-1:0]  ofs;
    logic [SH_W-1:0]   shamt;
    logic              shamt_hi;
  } insn_fields_t;

  function automatic logic [OPND_W-1:0] zext_half(input logic [HALF_W-1:0] v);
    return {{(OPND_W-HALF_W){1'b0}}, v};
  endfunction

  function automatic logic [OPND_W-1:0] sext_half(input logic [HALF_W-1:0] v);
    return {{(OPND_W-HALF_W){v[HALF_W-1]}}, v};
  endfunction

  function automatic logic [OPND_W-1:0] zext_high(input logic [HALF_W-1:0] v);
    return {{(OPND_W-2*HALF_W){1'b0}}, v, {HALF_W{1'b0}}};
  endfunction

  function automatic logic [OPND_W-1:0] sext_high(input logic [HALF_W-1:0] v);
    return {{(OPND_W-2*HALF_W){v[HALF_W-1]}}, v, {HALF_W{1'b0}}};
  endfunction

  function automatic logic [OPND_W-1:0] word_align(input logic [JMP_W-1:0] v);
    return {{(OPND_W-JMP_W-2){1'b0}}, v, 2'b00};
  endfunction
endpackage

// File: rtl/imm_field_extract.sv
module imm_field_extract
  import imm_gen_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_fields_t      fields
);
  // Big-endian bit k of the word sits at insn[INSN_W-1-k].
  localparam int unsigned HALF_LSB = INSN_W - 1 - 31;
  localparam int unsigned JMP_LSB  = INSN_W - 1 - 29;
  localparam int unsigned OFS_LSB  = INSN_W - 1 - 29;
  localparam int unsigned SH_LSB   = INSN_W - 1 - 20;
  localparam int unsigned SHHI_POS = INSN_W - 1 - 30;

  logic unused_opcode;
  assign unused_opcode = ^insn[INSN_W-1:JMP_LSB+JMP_W];

  assign fields.half     = insn[HALF_LSB +: HALF_W];
  assign fields.jump     = insn[JMP_LSB  +: JMP_W];
  assign fields.ofs      = insn[OFS_LSB  +: OFS_W];
  assign fields.shamt    = insn[SH_LSB   +: SH_W];
  assign fields.shamt_hi = insn[SHHI_POS];
endmodule

// File: rtl/imm_format_mux.sv
module imm_format_mux
  import imm_gen_pkg::*;
(
  input  insn_fields_t      fields,
  input  logic [SEL_W-1:0]  sel,
  output logic [OPND_W-1:0] raw_value,
  output logic              is_const,
  output logic              is_bad
);
  always_comb begin
    raw_value = '0;
    is_const  = 1'b1;
    is_bad    = 1'b0;
    case (imm_sel_e'(sel))
      SEL_NONE, SEL_GPR, SEL_SPREG: is_const = 1'b0;
      SEL_U16:    raw_value = zext_half(fields.half);
      SEL_S16:    raw_value = sext_half(fields.half);
      SEL_U16_HI: raw_value = zext_high(fields.half);
      SEL_S16_HI: raw_value = sext_high(fields.half);
      SEL_JUMP:   raw_value = word_align(fields.jump);
      SEL_BRANCH, SEL_DISP:
                  raw_value = word_align({{(JMP_W-OFS_W){1'b0}}, fields.ofs});
      SEL_ONES:   raw_value = '1;
      SEL_SHAMT6: raw_value = {{(OPND_W-SH_W-1){1'b0}}, fields.shamt_hi, fields.shamt};
      SEL_SHAMT5: raw_value = {{(OPND_W-SH_W){1'b0}}, fields.shamt};
      default: begin
        is_const = 1'b0;
        is_bad   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/imm_operand_gen.sv
module imm_operand_gen
  import imm_gen_pkg::*;
(
  input  logic [31:0] insn,
  input  logic [3:0]  opnd_sel,
  output logic [63:0] imm_value,
  output logic        imm_valid,
  output logic        bad_sel
);
  insn_fields_t      fields;
  logic [OPND_W-1:0] raw_value;
  logic              is_const;
  logic              is_bad;

  imm_field_extract u_extract (
    .insn   (insn),
    .fields (fields)
  );

  imm_format_mux u_mux (
    .fields    (fields),
    .sel       (opnd_sel),
    .raw_value (raw_value),
    .is_const  (is_const),
    .is_bad    (is_bad)
  );

  // Output gate: data only leaves when the mode is a constant.
  assign imm_value = is_const ? raw_value : '0;
  assign imm_valid = is_const;
  assign bad_sel   = is_bad;

  always_comb begin
    a_r11_idle_is_zero: assert (imm_valid || imm_value == '0);
    a_r12_flags_exclusive: assert ($countones({imm_valid, bad_sel}) <= 1);
    if (opnd_sel == SEL_S16_HI)
      a_r4_upper_fill: assert (imm_value[63:32] == {32{imm_value[31]}});
    if (opnd_sel == SEL_S16)
      a_r2_upper_fill: assert (imm_value[63:16] == {48{imm_value[15]}});
    if (opnd_sel == SEL_U16)
      a_r1_upper_clear: assert (imm_value[63:16] == '0);
    if (opnd_sel == SEL_JUMP || opnd_sel == SEL_BRANCH || opnd_sel == SEL_DISP)
      a_r6_word_aligned: assert (imm_value[1:0] == 2'b00);
    if (opnd_sel == SEL_ONES)
      a_r7_all_set: assert (&imm_value);
    if (opnd_sel == SEL_SHAMT6)
      a_r8_six_bits: assert (imm_value[63:6] == '0);
  end
endmodule

// File: tb/imm_operand_gen_tb_top.sv
module imm_operand_gen_tb_top;
  logic        clk = 1'b0;
  logic [31:0] insn = '0;
  logic [3:0]  opnd_sel = '0;
  logic [63:0] imm_value;
  logic        imm_valid;
  logic        bad_sel;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  imm_operand_gen dut_i (
    .insn      (insn),
    .opnd_sel  (opnd_sel),
    .imm_value (imm_value),
    .imm_valid (imm_valid),
    .bad_sel   (bad_sel)
  );

  // Big-endian numbered field [a..b], assembled MSB first.
  function automatic logic [63:0] be_field(input logic [31:0] w, input int a, input int b);
    logic [63:0] r = '0;
    for (int k = a; k <= b; k++) r = (r << 1) | 64'(w[31-k]);
    return r;
  endfunction

  function automatic logic [63:0] exp_value(input logic [31:0] w, input int code);
    logic [63:0] h = be_field(w, 16, 31);
    case (code)
      3:  return h;
      4:  return h[15] ? (h | 64'hFFFF_FFFF_FFFF_0000) : h;
      5:  return h << 16;
      6:  return h[15] ? ((h << 16) | 64'hFFFF_FFFF_0000_0000) : (h << 16);
      7:  return be_field(w, 6, 29) * 4;
      8, 9: return be_field(w, 16, 29) * 4;
      10: return ~64'd0;
      11: return be_field(w, 16, 20) + (be_field(w, 30, 30) * 32);
      12: return be_field(w, 16, 20);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string req_tag(input int code);
    case (code)
      3: return "R1"; 4: return "R2"; 5: return "R3"; 6: return "R4";
      7: return "R5"; 8, 9: return "R6"; 10: return "R7";
      11: return "R8"; 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input int code);
    logic exp_v;
    logic exp_b;
    @(posedge clk);
    insn     = w;
    opnd_sel = 4'(code);
    @(negedge clk);
    exp_v = (code >= 3 && code <= 12);
    exp_b = (code >= 13);
    n_chk++;
    if (imm_value !== exp_value(w, code)) begin
      n_bad++;
      $display("FAIL %s value sel=%0d insn=%h got %h exp %h",
               req_tag(code), code, w, imm_value, exp_value(w, code));
    end
    n_chk++;
    if (imm_valid !== exp_v) begin
      n_bad++;
      $display("FAIL R10 valid sel=%0d got %b exp %b", code, imm_valid, exp_v);
    end
    n_chk++;
    if (bad_sel !== exp_b) begin
      n_bad++;
      $display("FAIL R12 bad_sel sel=%0d got %b exp %b", code, bad_sel, exp_b);
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    // Reset-state / idle: all-zero inputs, code 0 (R10, R11).
    apply(32'h0, 0);
    // Sign boundaries for R2 and R4.
    apply(32'h0000_8000, 4);
    apply(32'h0000_7FFF, 4);
    apply(32'h0000_8000, 6);
    apply(32'h0000_7FFF, 6);
    apply(32'hFFFF_FFFF, 3);
    apply(32'hFFFF_FFFF, 5);
    // R5/R6 boundaries: field ends and top opcode bits.
    apply(32'h03FF_FFFC, 7);
    apply(32'hFC00_0003, 7);
    apply(32'h0000_FFFF, 8);
    apply(32'h0000_0001, 9);
    // R8: high shift bit alone, then low bits alone.
    apply(32'h0000_0002, 11);
    apply(32'h0000_F800, 11);
    apply(32'h0000_0002, 12);
    // R7, R12 and register codes with a busy word (R11).
    apply(32'h0, 10);
    apply(32'hFFFF_FFFF, 1);
    apply(32'hFFFF_FFFF, 2);
    apply(32'hFFFF_FFFF, 13);
    apply(32'hFFFF_FFFF, 15);
    for (int i = 0; i < 2000; i++)
      apply($urandom(), int'($urandom_range(15, 0)));
    for (int c = 0; c < 16; c++)
      apply($urandom(), c);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got hung exp done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule